// File: doc/BRIEF.md
# Concurrent BIST Register Pair

This block replaces an ordinary N-bit register whose outputs feed logic that loops back into the same register, such as a state register whose next value is computed from its present value. It holds two ranks of N flip-flops. The generator rank produces pseudo-random test patterns with a linear feedback shift register. The signature rank compacts the returning responses as a multiple-input signature register. Because the two ranks are separate, both jobs run in the same clock. Signatures never feed back as patterns, so the generator runs through its full maximal-length sequence.

A two-bit mode input selects the function. In system mode the signature rank is the working register. In test mode the generator drives the outputs while the signature rank compacts. In scan mode both ranks form one shift chain, which is used to seed the generator and to read out the signature. A hold mode freezes both ranks.

Top module: `cbist_pair`

## Requirements
- R1: An active-low reset clears both ranks at once, without waiting for a clock edge. After reset `qOut` and `scanOut` read 0.
- R2: With `modeSel` = 2'b00 (system), every clock loads `sysIn` into the signature rank and the generator rank keeps its value. `qOut` shows the signature rank.
- R3: With `modeSel` = 2'b01 (test), `qOut` shows the generator rank. Each clock the generator shifts one place toward its MSB, and bit 0 takes the XOR of the bits selected by `TAP_MASK` (default 8'hB8, which is x^8+x^6+x^5+x^4+1).
- R4: In the same test-mode clock, the signature rank becomes its own LFSR step under the same tap mask, XORed bitwise with `sysIn`.
- R5: With `modeSel` = 2'b10 (scan), the chain runs `scanIn` → generator bit 0 → generator MSB → signature bit 0 → signature MSB. `scanOut` always shows the signature MSB, and `qOut` shows the signature rank. A full load or unload takes 2N clocks.
- R6: With `modeSel` = 2'b11 (hold), neither rank changes, whatever `sysIn` is, and `qOut` shows the signature rank.
- R7: From any non-zero seed, the generator in test mode passes through 2^N-1 distinct non-zero states before it returns to the seed. This holds even while its outputs loop back through logic into `sysIn`.
- R8: A generator rank that holds all zeros stays at zero in test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | 00 system, 01 test, 10 scan, 11 hold |
| sysIn | input | N | Data returning from the surrounding logic |
| scanIn | input | 1 | Serial input to the generator rank |
| qOut | output | N | Register output to the surrounding logic |
| scanOut | output | 1 | Serial output, the signature rank MSB |

## Verification
Pattern generation and response compaction happen in the same test-mode clock. The bench provokes this by wrapping a next-state function around the pair: `sysIn` is derived from `qOut` in the same cycle, so every generated pattern immediately returns as a response. Each clock a reference model of both ranks predicts `qOut` and `scanOut`. The bench also confirms that the generator's period and distinct-state count stay maximal while the signature evolves alongside it. A final scan unload compares the compacted signature bit by bit.

// File: rtl/cbist_pkg.sv
package cbist_pkg;

  typedef enum logic [1:0] {
    MODE_SYS  = 2'b00,
    MODE_TEST = 2'b01,
    MODE_SCAN = 2'b10,
    MODE_HOLD = 2'b11
  } cbistMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic genStep;    // generator advances as LFSR
    logic genShift;   // generator shifts from scanIn
    logic sigLoad;    // signature rank loads system data
    logic sigCompact; // signature rank acts as MISR
    logic sigShift;   // signature rank shifts from generator MSB
    logic qFromGen;   // output mux selects generator rank
  } cbistStrobe_t;

endpackage

// File: rtl/cbist_ctrl.sv
module cbist_ctrl
  import cbist_pkg::*;
(
  input  logic [1:0]   modeSel,
  output cbistStrobe_t strb
);

  cbistMode_e mode;

  always_comb begin
    mode = cbistMode_e'(modeSel);
    strb = '0;
    unique case (mode)
      MODE_SYS:  strb.sigLoad = 1'b1;
      MODE_TEST: begin
        strb.genStep    = 1'b1;
        strb.sigCompact = 1'b1;
        strb.qFromGen   = 1'b1;
      end
      MODE_SCAN: begin
        strb.genShift = 1'b1;
        strb.sigShift = 1'b1;
      end
      MODE_HOLD: strb = '0;
      default:   strb = '0;
    endcase
  end

endmodule

// File: rtl/cbist_dp.sv
module cbist_dp
  import cbist_pkg::*;
#(
  parameter int          N        = 8,
  parameter logic [N-1:0] TAP_MASK = 8'hB8
) (
  input  logic         clk,
  input  logic         rstN,
  input  cbistStrobe_t strb,
  input  logic [N-1:0] sysIn,
  input  logic         scanIn,
  output logic [N-1:0] qOut,
  output logic         scanOut
);

  localparam int MSB = N - 1;

  logic [N-1:0] genRank, genNext;
  logic [N-1:0] sigRank, sigNext;
  logic         genFb, sigFb;
  logic [N-1:0] genShiftIn, sigShiftIn;

  assign genFb = ^(genRank & TAP_MASK);
  assign sigFb = ^(sigRank & TAP_MASK);

  // per-bit serial input for each rank
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_head
      assign genShiftIn[i] = strb.genShift ? scanIn : genFb;
      assign sigShiftIn[i] = strb.sigShift ? genRank[MSB] : sigFb;
    end else begin : g_body
      assign genShiftIn[i] = genRank[i-1];
      assign sigShiftIn[i] = sigRank[i-1];
    end
  end

  always_comb begin
    genNext = genRank;
    if (strb.genStep || strb.genShift) genNext = genShiftIn;
  end

  always_comb begin
    sigNext = sigRank;
    if (strb.sigLoad)         sigNext = sysIn;
    else if (strb.sigCompact) sigNext = sigShiftIn ^ sysIn;
    else if (strb.sigShift)   sigNext = sigShiftIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genRank <= '0;
      sigRank <= '0;
    end else begin
      genRank <= genNext;
      sigRank <= sigNext;
    end
  end

  assign qOut    = strb.qFromGen ? genRank : sigRank;
  assign scanOut = sigRank[MSB];

  p_sys_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.sigLoad |=> (sigRank == $past(sysIn)));

  p_gen_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.sigLoad |=> $stable(genRank));

  p_scan_link_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.sigShift |=> (sigRank[0] == $past(genRank[MSB])) && (genRank[0] == $past(scanIn)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> ($stable(genRank) && $stable(sigRank)));

  p_gen_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.genStep && (genRank != '0)) |=> (genRank != '0));

  p_zero_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.genStep && (genRank == '0)) |=> (genRank == '0));

endmodule

// File: rtl/cbist_pair.sv
module cbist_pair
  import cbist_pkg::*;
#(
  parameter int           N        = 8,
  parameter logic [N-1:0] TAP_MASK = 8'hB8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   modeSel,
  input  logic [N-1:0] sysIn,
  input  logic         scanIn,
  output logic [N-1:0] qOut,
  output logic         scanOut
);

  cbistStrobe_t strb;

  cbist_ctrl u_ctrl (
    .modeSel (modeSel),
    .strb    (strb)
  );

  cbist_dp #(.N(N), .TAP_MASK(TAP_MASK)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .sysIn   (sysIn),
    .scanIn  (scanIn),
    .qOut    (qOut),
    .scanOut (scanOut)
  );

  p_test_q_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01) |-> strb.qFromGen);

endmodule

// File: tb/sim_cbist_pair.sv
`timescale 1ns/1ps
module sim_cbist_pair;

  localparam int N = 8;
  localparam logic [N-1:0] TAP = 8'hB8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   modeSel = 2'b11;
  logic [N-1:0] sysIn;
  logic [N-1:0] sysManual = '0;
  logic         loopEn = 1'b0;
  logic         scanIn = 1'b0;
  logic [N-1:0] qOut;
  logic         scanOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [N-1:0] nextFn(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]} ^ 8'h3C;
  endfunction

  assign sysIn = loopEn ? nextFn(qOut) : sysManual;

  cbist_pair #(.N(N), .TAP_MASK(TAP)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sysIn(sysIn),
    .scanIn(scanIn), .qOut(qOut), .scanOut(scanOut)
  );

  typedef struct {
    logic [N-1:0] q;
    logic         so;
    string        tag;
  } item_t;

  item_t sbQ[$];
  logic [N-1:0] mGen = '0, mSig = '0;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle and pushes the predicted outputs
  task automatic step(input logic [1:0] m, input logic si, input string tag);
    logic [N-1:0] curQ, dIn;
    item_t it;
    modeSel = m;
    scanIn  = si;
    curQ = (m == 2'b01) ? mGen : mSig;
    dIn  = loopEn ? nextFn(curQ) : sysManual;
    @(posedge clk);
    case (m)
      2'b00: mSig = dIn;
      2'b01: begin
        mSig = {mSig[N-2:0], ^(mSig & TAP)} ^ dIn;
        mGen = {mGen[N-2:0], ^(mGen & TAP)};
      end
      2'b10: begin
        mSig = {mSig[N-2:0], mGen[N-1]};
        mGen = {mGen[N-2:0], si};
      end
      default: ;
    endcase
    it.q   = (m == 2'b01) ? mGen : mSig;
    it.so  = mSig[N-1];
    it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        check({it.tag, " q"}, qOut, it.q);
        check({it.tag, " scanOut"}, {{(N-1){1'b0}}, scanOut}, {{(N-1){1'b0}}, it.so});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2*N-1:0] pattern;
    logic [N-1:0]   seed;
    bit             seen [256];
    int             distinct;
    #12;
    check("R1 reset q", qOut, '0);
    check("R1 reset scanOut", {{(N-1){1'b0}}, scanOut}, '0);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R2: system mode loads
    loopEn = 1'b0;
    foreach (pattern[i]) seen[i] = 0;
    sysManual = 8'hA5; step(2'b00, 1'b0, "R2 load A5");
    sysManual = 8'h3C; step(2'b00, 1'b0, "R2 load 3C");
    sysManual = 8'hFF; step(2'b00, 1'b0, "R2 load FF");
    sysManual = 8'h5E; step(2'b00, 1'b0, "R2 load 5E");

    // R6: hold ignores sysIn
    sysManual = 8'h00; step(2'b11, 1'b1, "R6 hold");
    sysManual = 8'h99; step(2'b11, 1'b0, "R6 hold");

    // R5: scan in generator seed and signature start value
    seed = 8'h01;
    pattern = {8'hC3, seed};
    for (int k = 2*N-1; k >= 0; k--) step(2'b10, pattern[k], "R5 scan load");

    // R3 R4 R7: concurrent generate and compact with loop-back
    for (int i = 0; i < 256; i++) seen[i] = 0;
    distinct = 0;
    loopEn = 1'b1;
    for (int s = 0; s < 255; s++) begin
      step(2'b01, 1'b0, "R3 R4 test");
      if (!seen[qOut]) begin
        seen[qOut] = 1;
        distinct++;
      end
    end
    check("R7 distinct states", distinct[N-1:0], 8'hFF);
    check("R7 return to seed", qOut, seed);
    check("R7 zero never seen", {{(N-1){1'b0}}, seen[0]}, '0);

    // R5: unload signature and generator
    loopEn = 1'b0;
    for (int k = 0; k < 2*N; k++) step(2'b10, 1'b0, "R5 scan unload");

    // R8: all-zero generator is stuck
    loopEn = 1'b1;
    for (int k = 0; k < 4; k++) step(2'b01, 1'b0, "R8 zero lock");

    // R1: asynchronous reset mid-run
    loopEn = 1'b0;
    sysManual = 8'h77; step(2'b00, 1'b0, "R2 load 77");
    #1;
    rstN = 1'b0;
    #1;
    check("R1 async clear q", qOut, '0);
    check("R1 async clear scanOut", {{(N-1){1'b0}}, scanOut}, '0);

    wait (sbQ.size() == 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule